// File: doc/BRIEF.md
# Processor bus cycle controller

This block sits between a 32-bit processor core and its external system bus. The core hands it one transfer at a time over a valid/ready handshake. Each transfer carries an address, a direction, a memory-or-I/O selector, a data-or-control selector, four byte enables, a lock flag and write data. The controller turns each transfer into a bus cycle. It pulses an active-low address strobe with the address and the cycle definition. It then waits for an active-low ready input, and it returns a one-clock done pulse with the read data.

Slow or narrow devices shape the cycle from the bus side. A wait state is added for every clock in which ready is not asserted. An active-low 16-bit size input, sampled with ready, makes the block finish a transfer that spans both halves of the bus as two half-width cycles. An active-low next-address input lets the following transfer put its address out before the current cycle ends. Another master can take the bus through a hold request and acknowledge handshake. A sequence of locked transfers keeps that master out until the sequence ends.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While reset is high and on the clock after it, ads_n_o=1, be_n_o=4'b1111, lock_n_o=1, hlda_o=0, bus_oe_o=1, done_o=0, and req_ready=1 while hold_i is low.
- R2: A request accepted at a clock edge in idle gives, after that edge, ads_n_o=0 for exactly one clock, with addr_o=req_addr, be_n_o=~req_be, wr_o=req_write (1 = write), mem_o=req_mem (1 = memory), dc_o=req_data (1 = data, 0 = control).
- R3: ready_n_i is sampled from the second clock of a cycle onward. Each edge at which it is high adds a wait state, with addr_o, be_n_o and wr_o unchanged and done_o low. The first edge at which it is low ends the cycle, and done_o=1 follows for one clock with rdata_o equal to rdata_i at that edge.
- R4: If bs16_n_i is low at the edge that ends the first cycle of a transfer with req_be[1:0] and req_be[3:2] both nonzero, no done is given. Instead, on the next clock, a second cycle starts with ads_n_o=0, addr_o = first address + 2, be_n_o={2'b11, ~req_be[3:2]} and wdata_o[15:0]=req_wdata[31:16].
- R5: A split read returns rdata_o = {rdata_i[15:0] of the second cycle, rdata_i[15:0] of the first cycle}.
- R6: With bs16_n_i low but only one half of req_be active, the transfer ends after one cycle with rdata_o=rdata_i and no second strobe.
- R7: With hold_i high in idle, req_ready=0. From the next clock, hlda_o=1, bus_oe_o=0 and ads_n_o=1, until hold_i is sampled low. A hold raised during a cycle is acknowledged only after that cycle ends.
- R8: lock_n_o is low from the strobe of a locked request. It stays low when another locked request is presented in the idle clock after a locked transfer ends. That request is accepted in preference to a pending hold, and hlda_o stays 0 while lock_n_o is low.
- R9: When na_n_i is low and ready_n_i is high in a wait clock, a next request is accepted (req_ready=1) and its address is strobed on the next clock, while wdata_o keeps the current write data. This needs hold_i low and a current cycle that cannot split, meaning one half of its byte enables is unused or it is already the second half. Otherwise req_ready=0.
- R10: After a pipelined address, the edge with ready_n_i low ends the current transfer (done_o=1). The pipelined transfer then ends at the next edge with ready_n_i low, with no further strobe.
- R11: Reset aborts a cycle in progress: no done pulse follows, and the strobes return to their R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core has a transfer to issue |
| req_ready | output | 1 | Transfer is accepted at this edge if valid |
| req_addr | input | 32 | Byte address of the transfer |
| req_be | input | 4 | Active-high byte enables |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory, 0 = I/O |
| req_data | input | 1 | 1 = data, 0 = control cycle |
| req_lock | input | 1 | Transfer belongs to a locked sequence |
| req_wdata | input | 32 | Write data |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 32 | Read data, valid with done_o |
| ads_n_o | output | 1 | Active-low address strobe |
| addr_o | output | 32 | Bus address |
| be_n_o | output | 4 | Active-low byte enables |
| wr_o | output | 1 | Write/read definition |
| mem_o | output | 1 | Memory/I/O definition |
| dc_o | output | 1 | Data/control definition |
| lock_n_o | output | 1 | Active-low bus lock |
| wdata_o | output | 32 | Bus write data |
| rdata_i | input | 32 | Bus read data |
| ready_n_i | input | 1 | Active-low cycle end |
| bs16_n_i | input | 1 | Active-low 16-bit bus size |
| na_n_i | input | 1 | Active-low next-address request |
| hold_i | input | 1 | Bus request from another master |
| hlda_o | output | 1 | Bus granted to the other master |
| bus_oe_o | output | 1 | Bus output enable, low while granted |

## Verification
A hold request and a continued locked request can meet in the same idle clock: the one right after a locked transfer ends. The bench raises hold_i together with a second locked request in that clock. It expects req_ready high, a fresh strobe with hlda_o still low, and the grant only after the locked sequence has ended. A next-address request and a cycle end can also meet. The bench holds ready low across the pipelined strobe and judges each of the two done pulses by its own completion edge.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  parameter int unsigned ADDR_W = 32;
  parameter int unsigned DATA_W = 32;
  localparam int unsigned BE_W    = DATA_W / 8;
  localparam int unsigned HALF_BE = BE_W / 2;
  localparam int unsigned HALF_W  = DATA_W / 2;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [BE_W-1:0]   be;
    logic              write;
    logic              mem;
    logic              dcyc;
    logic              lock;
    logic [DATA_W-1:0] wdata;
  } bcc_req_t;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_T1   = 3'd1,
    S_T2   = 3'd2,
    S_T2P  = 3'd3,
    S_HOLD = 3'd4
  } bcc_state_t;

  // Both lane halves carry at least one enabled byte.
  function automatic logic bcc_both(input logic [BE_W-1:0] be);
    return (|be[HALF_BE-1:0]) && (|be[BE_W-1:HALF_BE]);
  endfunction

  // Upper half of the write data copied onto the lower lanes for a second half cycle.
  function automatic logic [DATA_W-1:0] bcc_wdata(input logic [DATA_W-1:0] w,
                                                  input logic upper);
    return upper ? {w[DATA_W-1:HALF_W], w[DATA_W-1:HALF_W]} : w;
  endfunction
endpackage

// File: rtl/bcc_lane_map.sv
module bcc_lane_map
  import bcc_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic              upper_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BE_W-1:0]   be_n_o
);
  localparam int unsigned STEP = HALF_BE;

  always_comb begin
    if (upper_i) begin
      addr_o = addr_i + ADDR_W'(STEP);
      be_n_o = {{HALF_BE{1'b1}}, ~be_i[BE_W-1:HALF_BE]};
    end else begin
      addr_o = addr_i;
      be_n_o = ~be_i;
    end
  end
endmodule

// File: rtl/bcc_rd_assemble.sv
module bcc_rd_assemble
  import bcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_lo_i,
  input  logic              fin_i,
  input  logic              fin_split_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [HALF_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= '0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= fin_i;
      if (cap_lo_i) lo_q <= rdata_i[HALF_W-1:0];
      if (fin_i) rdata_o <= fin_split_i ? {rdata_i[HALF_W-1:0], lo_q} : rdata_i;
    end
  end
endmodule

// File: rtl/bcc_seq.sv
module bcc_seq
  import bcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  bcc_req_t          req_in,
  input  logic              ready_n_i,
  input  logic              bs16_n_i,
  input  logic              na_n_i,
  input  logic              hold_i,
  output logic              ads_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BE_W-1:0]   be_n_o,
  output logic              wr_o,
  output logic              mem_o,
  output logic              dc_o,
  output logic              lock_n_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              hlda_o,
  output logic              bus_oe_o,
  output logic              cap_lo_o,
  output logic              fin_o,
  output logic              fin_split_o
);
  bcc_state_t state, state_n;
  bcc_req_t   cur, nxt, pres_req;
  logic       cur_half, lock_act, lock_act_n;
  logic       lock_cont, cur_final, idle_ok, na_ok, take_idle, take_na;
  logic       rdy_edge, split_now, fin, pres_load;
  logic [ADDR_W-1:0] map_addr;
  logic [BE_W-1:0]   map_be_n;

  assign lock_cont = lock_act && req_valid && req_in.lock;
  assign cur_final = cur_half || !bcc_both(cur.be);
  assign idle_ok   = (state == S_IDLE) && (!hold_i || lock_cont);
  assign na_ok     = (state == S_T2) && !na_n_i && ready_n_i && cur_final && !hold_i;
  assign req_ready = idle_ok || na_ok;
  assign take_idle = idle_ok && req_valid;
  assign take_na   = na_ok && req_valid;
  assign rdy_edge  = ((state == S_T2) || (state == S_T2P)) && !ready_n_i;
  assign split_now = rdy_edge && (state == S_T2) && !cur_half &&
                     bcc_both(cur.be) && !bs16_n_i;
  assign fin       = rdy_edge && !split_now;
  assign pres_load = take_idle || take_na || split_now;
  assign pres_req  = split_now ? cur : req_in;

  assign cap_lo_o    = split_now;
  assign fin_o       = fin;
  assign fin_split_o = fin && cur_half;
  assign lock_n_o    = ~lock_act;

  bcc_lane_map u_map (
    .addr_i (pres_req.addr),
    .be_i   (pres_req.be),
    .upper_i(split_now),
    .addr_o (map_addr),
    .be_n_o (map_be_n)
  );

  always_comb begin
    state_n    = state;
    lock_act_n = lock_act;
    case (state)
      S_IDLE: begin
        lock_act_n = take_idle && req_in.lock;
        if (take_idle)   state_n = S_T1;
        else if (hold_i) state_n = S_HOLD;
      end
      S_T1: state_n = S_T2;
      S_T2: begin
        if (split_now)  state_n = S_T1;
        else if (fin)   state_n = S_IDLE;
        else if (take_na) begin
          state_n    = S_T2P;
          lock_act_n = cur.lock || req_in.lock;
        end
      end
      S_T2P: begin
        if (rdy_edge) begin
          state_n    = S_T2;
          lock_act_n = nxt.lock;
        end
      end
      S_HOLD: if (!hold_i) state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cur      <= '0;
      nxt      <= '0;
      cur_half <= 1'b0;
      lock_act <= 1'b0;
      ads_n_o  <= 1'b1;
      addr_o   <= '0;
      be_n_o   <= '1;
      wr_o     <= 1'b0;
      mem_o    <= 1'b0;
      dc_o     <= 1'b0;
      wdata_o  <= '0;
      hlda_o   <= 1'b0;
      bus_oe_o <= 1'b1;
    end else begin
      state    <= state_n;
      lock_act <= lock_act_n;
      hlda_o   <= (state_n == S_HOLD);
      bus_oe_o <= (state_n != S_HOLD);
      ads_n_o  <= !pres_load;
      if (pres_load) begin
        addr_o <= map_addr;
        be_n_o <= map_be_n;
        wr_o   <= pres_req.write;
        mem_o  <= pres_req.mem;
        dc_o   <= pres_req.dcyc;
      end
      if (take_idle) begin
        cur      <= req_in;
        cur_half <= 1'b0;
        wdata_o  <= bcc_wdata(req_in.wdata, 1'b0);
      end
      if (split_now) begin
        cur_half <= 1'b1;
        wdata_o  <= bcc_wdata(cur.wdata, 1'b1);
      end
      if (take_na) nxt <= req_in;
      if ((state == S_T2P) && rdy_edge) begin
        cur      <= nxt;
        cur_half <= 1'b0;
        wdata_o  <= bcc_wdata(nxt.wdata, 1'b0);
      end
    end
  end

  // R2: the strobe lasts a single clock
  a_r2_ads_single: assert property (@(posedge clk) disable iff (rst)
    !ads_n_o |=> ads_n_o);

  // R3: wait states leave the cycle definition untouched
  a_r3_wait_stable: assert property (@(posedge clk) disable iff (rst)
    ((state == S_T2) && ready_n_i && na_n_i) |=>
      ($stable(addr_o) && $stable(be_n_o) && $stable(wr_o) && ads_n_o));

  // R4: second half strobed at the advanced address
  a_r4_split_addr: assert property (@(posedge clk) disable iff (rst)
    split_now |=> (!ads_n_o && (addr_o == $past(addr_o) + ADDR_W'(HALF_BE))));

  // R7: granted bus is quiet
  a_r7_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    hlda_o |-> (!bus_oe_o && ads_n_o));

  // R8: no grant while locked
  a_r8_lock_no_grant: assert property (@(posedge clk) disable iff (rst)
    !lock_n_o |-> !hlda_o);
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic              req_write,
  input  logic              req_mem,
  input  logic              req_data,
  input  logic              req_lock,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ads_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BE_W-1:0]   be_n_o,
  output logic              wr_o,
  output logic              mem_o,
  output logic              dc_o,
  output logic              lock_n_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              ready_n_i,
  input  logic              bs16_n_i,
  input  logic              na_n_i,
  input  logic              hold_i,
  output logic              hlda_o,
  output logic              bus_oe_o
);
  bcc_req_t req_in;
  logic     cap_lo, fin, fin_split;

  assign req_in = '{addr: req_addr, be: req_be, write: req_write, mem: req_mem,
                    dcyc: req_data, lock: req_lock, wdata: req_wdata};

  bcc_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_in     (req_in),
    .ready_n_i  (ready_n_i),
    .bs16_n_i   (bs16_n_i),
    .na_n_i     (na_n_i),
    .hold_i     (hold_i),
    .ads_n_o    (ads_n_o),
    .addr_o     (addr_o),
    .be_n_o     (be_n_o),
    .wr_o       (wr_o),
    .mem_o      (mem_o),
    .dc_o       (dc_o),
    .lock_n_o   (lock_n_o),
    .wdata_o    (wdata_o),
    .hlda_o     (hlda_o),
    .bus_oe_o   (bus_oe_o),
    .cap_lo_o   (cap_lo),
    .fin_o      (fin),
    .fin_split_o(fin_split)
  );

  bcc_rd_assemble u_rd (
    .clk        (clk),
    .rst        (rst),
    .cap_lo_i   (cap_lo),
    .fin_i      (fin),
    .fin_split_i(fin_split),
    .rdata_i    (rdata_i),
    .done_o     (done_o),
    .rdata_o    (rdata_o)
  );
endmodule

// File: tb/tb_bus_cycle_ctrl.sv
`timescale 1ns/1ps
module tb_bus_cycle_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic        req_write = 1'b0, req_mem = 1'b1, req_data = 1'b1, req_lock = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        done_o;
  logic [31:0] rdata_o, addr_o, wdata_o;
  logic        ads_n_o, wr_o, mem_o, dc_o, lock_n_o, hlda_o, bus_oe_o;
  logic [3:0]  be_n_o;
  logic [31:0] rdata_i = '0;
  logic        ready_n_i = 1'b1, bs16_n_i = 1'b1, na_n_i = 1'b1, hold_i = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;

  bus_cycle_ctrl dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_be(req_be), .req_write(req_write), .req_mem(req_mem),
    .req_data(req_data), .req_lock(req_lock), .req_wdata(req_wdata),
    .done_o(done_o), .rdata_o(rdata_o), .ads_n_o(ads_n_o), .addr_o(addr_o),
    .be_n_o(be_n_o), .wr_o(wr_o), .mem_o(mem_o), .dc_o(dc_o), .lock_n_o(lock_n_o),
    .wdata_o(wdata_o), .rdata_i(rdata_i), .ready_n_i(ready_n_i), .bs16_n_i(bs16_n_i),
    .na_n_i(na_n_i), .hold_i(hold_i), .hlda_o(hlda_o), .bus_oe_o(bus_oe_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_req(input logic [31:0] a, input logic [3:0] be, input logic w,
                         input logic lk, input logic [31:0] wd);
    req_addr = a; req_be = be; req_write = w; req_lock = lk; req_wdata = wd;
    req_valid = 1'b1;
  endtask

  // Leaves the bench at the falling edge of the strobe clock.
  task automatic issue(input logic [31:0] a, input logic [3:0] be, input logic w,
                       input logic lk, input logic [31:0] wd);
    @(negedge clk);
    set_req(a, be, w, lk, wd);
    step();
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 ads_n", 32'(ads_n_o), 32'd1);
    chk("R1 be_n", 32'(be_n_o), 32'hF);
    rst = 1'b0;
    step();
    chk("R1 lock_n", 32'(lock_n_o), 32'd1);
    chk("R1 hlda", 32'(hlda_o), 32'd0);
    chk("R1 oe", 32'(bus_oe_o), 32'd1);
    chk("R1 done", 32'(done_o), 32'd0);
    chk("R1 req_ready", 32'(req_ready), 32'd1);
  endtask

  task automatic t_simple_read();
    req_mem = 1'b1; req_data = 1'b0;
    issue(32'h100, 4'hF, 1'b0, 1'b0, '0);
    chk("R2 ads_n", 32'(ads_n_o), 32'd0);
    chk("R2 addr", addr_o, 32'h100);
    chk("R2 be_n", 32'(be_n_o), 32'h0);
    chk("R2 wr", 32'(wr_o), 32'd0);
    chk("R2 mem", 32'(mem_o), 32'd1);
    chk("R2 dc", 32'(dc_o), 32'd0);
    req_data = 1'b1;
    ready_n_i = 1'b0; rdata_i = 32'hCAFE0001;
    step();
    chk("R2 strobe one clock", 32'(ads_n_o), 32'd1);
    step();
    chk("R3 done", 32'(done_o), 32'd1);
    chk("R3 rdata", rdata_o, 32'hCAFE0001);
    ready_n_i = 1'b1;
    step();
    chk("R3 done pulse ends", 32'(done_o), 32'd0);
  endtask

  task automatic t_wait_write();
    req_mem = 1'b0;
    issue(32'h204, 4'b0011, 1'b1, 1'b0, 32'h12345678);
    chk("R2 io mem", 32'(mem_o), 32'd0);
    chk("R2 wr write", 32'(wr_o), 32'd1);
    req_mem = 1'b1;
    step();
    step();
    chk("R3 wait done", 32'(done_o), 32'd0);
    chk("R3 wait addr", addr_o, 32'h204);
    chk("R3 wait wdata", wdata_o, 32'h12345678);
    step();
    chk("R3 wait2 done", 32'(done_o), 32'd0);
    chk("R3 wait2 be_n", 32'(be_n_o), 32'hC);
    ready_n_i = 1'b0;
    step();
    chk("R3 wait end done", 32'(done_o), 32'd1);
    ready_n_i = 1'b1;
  endtask

  task automatic t_split_read();
    issue(32'h300, 4'hF, 1'b0, 1'b0, '0);
    bs16_n_i = 1'b0;
    step();
    na_n_i = 1'b0;
    #1;
    chk("R9 na refused when split possible", 32'(req_ready), 32'd0);
    na_n_i = 1'b1;
    ready_n_i = 1'b0; rdata_i = 32'hAAAA1111;
    step();
    chk("R4 second strobe", 32'(ads_n_o), 32'd0);
    chk("R4 addr+2", addr_o, 32'h302);
    chk("R4 be_n", 32'(be_n_o), 32'hC);
    chk("R4 no done", 32'(done_o), 32'd0);
    ready_n_i = 1'b1;
    step();
    ready_n_i = 1'b0; rdata_i = 32'hBBBB2222;
    step();
    chk("R5 done", 32'(done_o), 32'd1);
    chk("R5 rdata", rdata_o, 32'h22221111);
    ready_n_i = 1'b1; bs16_n_i = 1'b1;
    step();
  endtask

  task automatic t_split_write();
    issue(32'h400, 4'hF, 1'b1, 1'b0, 32'hDEADBEEF);
    bs16_n_i = 1'b0;
    step();
    ready_n_i = 1'b0;
    step();
    chk("R4 wdata low lanes", 32'(wdata_o[15:0]), 32'hDEAD);
    ready_n_i = 1'b1;
    step();
    ready_n_i = 1'b0;
    step();
    chk("R4 write done", 32'(done_o), 32'd1);
    ready_n_i = 1'b1; bs16_n_i = 1'b1;
    step();
  endtask

  task automatic t_single_half();
    issue(32'h500, 4'b1100, 1'b0, 1'b0, '0);
    bs16_n_i = 1'b0;
    step();
    ready_n_i = 1'b0; rdata_i = 32'h77778888;
    step();
    chk("R6 done", 32'(done_o), 32'd1);
    chk("R6 rdata", rdata_o, 32'h77778888);
    chk("R6 no strobe", 32'(ads_n_o), 32'd1);
    ready_n_i = 1'b1; bs16_n_i = 1'b1;
    step();
    chk("R6 still no strobe", 32'(ads_n_o), 32'd1);
  endtask

  task automatic t_hold();
    @(negedge clk);
    hold_i = 1'b1;
    set_req(32'h600, 4'hF, 1'b0, 1'b0, '0);
    #1;
    chk("R7 req_ready low", 32'(req_ready), 32'd0);
    step();
    chk("R7 hlda", 32'(hlda_o), 32'd1);
    chk("R7 oe off", 32'(bus_oe_o), 32'd0);
    chk("R7 ads idle", 32'(ads_n_o), 32'd1);
    hold_i = 1'b0; req_valid = 1'b0;
    step();
    chk("R7 released", 32'(hlda_o), 32'd0);
    chk("R7 oe back", 32'(bus_oe_o), 32'd1);
    issue(32'h610, 4'hF, 1'b0, 1'b0, '0);
    step();
    hold_i = 1'b1;
    step();
    chk("R7 mid-cycle no grant", 32'(hlda_o), 32'd0);
    ready_n_i = 1'b0;
    step();
    chk("R7 cycle finishes", 32'(done_o), 32'd1);
    chk("R7 not yet granted", 32'(hlda_o), 32'd0);
    ready_n_i = 1'b1;
    step();
    chk("R7 granted after cycle", 32'(hlda_o), 32'd1);
    hold_i = 1'b0;
    step();
  endtask

  task automatic t_lock();
    issue(32'h700, 4'hF, 1'b1, 1'b1, 32'h1);
    chk("R8 lock at strobe", 32'(lock_n_o), 32'd0);
    step();
    ready_n_i = 1'b0;
    step();
    ready_n_i = 1'b1;
    hold_i = 1'b1;
    set_req(32'h704, 4'hF, 1'b1, 1'b1, 32'h2);
    #1;
    chk("R8 locked req wins over hold", 32'(req_ready), 32'd1);
    step();
    req_valid = 1'b0;
    chk("R8 second strobe", 32'(ads_n_o), 32'd0);
    chk("R8 second addr", addr_o, 32'h704);
    chk("R8 no grant", 32'(hlda_o), 32'd0);
    chk("R8 still locked", 32'(lock_n_o), 32'd0);
    step();
    ready_n_i = 1'b0;
    step();
    ready_n_i = 1'b1;
    step();
    chk("R8 grant after sequence", 32'(hlda_o), 32'd1);
    chk("R8 lock released", 32'(lock_n_o), 32'd1);
    hold_i = 1'b0;
    step();
  endtask

  task automatic t_pipeline();
    issue(32'h800, 4'b0011, 1'b1, 1'b0, 32'h11112222);
    step();
    na_n_i = 1'b0;
    set_req(32'h900, 4'hF, 1'b0, 1'b0, '0);
    #1;
    chk("R9 next accepted", 32'(req_ready), 32'd1);
    step();
    chk("R9 early strobe", 32'(ads_n_o), 32'd0);
    chk("R9 early addr", addr_o, 32'h900);
    chk("R9 wdata kept", wdata_o, 32'h11112222);
    chk("R9 no done yet", 32'(done_o), 32'd0);
    req_valid = 1'b0; na_n_i = 1'b1;
    ready_n_i = 1'b0; rdata_i = 32'h55556666;
    step();
    chk("R10 first done", 32'(done_o), 32'd1);
    chk("R10 no extra strobe", 32'(ads_n_o), 32'd1);
    step();
    chk("R10 second done", 32'(done_o), 32'd1);
    chk("R10 second rdata", rdata_o, 32'h55556666);
    ready_n_i = 1'b1;
    step();
    chk("R10 done ends", 32'(done_o), 32'd0);
  endtask

  task automatic t_reset_abort();
    issue(32'hA00, 4'hF, 1'b0, 1'b1, '0);
    rst = 1'b1;
    step();
    chk("R11 ads_n", 32'(ads_n_o), 32'd1);
    chk("R11 be_n", 32'(be_n_o), 32'hF);
    chk("R11 lock_n", 32'(lock_n_o), 32'd1);
    rst = 1'b0; ready_n_i = 1'b0;
    step();
    chk("R11 no done", 32'(done_o), 32'd0);
    step();
    chk("R11 still no done", 32'(done_o), 32'd0);
    ready_n_i = 1'b1;
  endtask

  initial begin
    t_reset();
    t_simple_read();
    t_wait_write();
    t_split_read();
    t_split_write();
    t_single_half();
    t_hold();
    t_lock();
    t_pipeline();
    t_reset_abort();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!ended) begin
      ended = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule